// File: doc/BRIEF.md
# Framed Serializer with Sync Insertion

This block turns parallel words into a continuous serial bit stream, one bit per clock. Every word goes out as a frame: a high start bit, the word's bits least significant first, then a low end bit. The end-to-start boundary therefore always carries a low-to-high edge that a receiver can recover a clock from. Frames follow each other with no gaps, and a one-cycle marker flags the cycle that carries each start bit.

Two independent sync request inputs replace the data with a training frame that has exactly one rising edge. The first half of that frame is ones and the second half is zeros. Either request may be wired straight to a receiver's lock-lost indication, so training frames keep going until the receiver locks again. Words are captured on a load strobe. The choice between data and training is made only at a frame boundary. A driver-enable input parks the line high without disturbing frame timing.

Top module: `framed_serializer`

## Requirements
- R1: Frames are FRAME_W = DATA_W+2 bits long (12 by default) and follow back to back. `frame_start` is high for exactly one cycle per frame, in the cycle whose `ser_out` bit is the start bit, and consecutive pulses are FRAME_W cycles apart.
- R2: A data frame is, in time order: a 1, then word bit 0 through bit DATA_W-1, then a 0.
- R3: A training frame is FRAME_W/2 cycles of 1 followed by FRAME_W/2 cycles of 0 (six and six by default).
- R4: A training frame is sent when `sync_req_a`, `sync_req_b` or both are high at the load edge. A word strobed in that same cycle is still captured, but it is not sent in that frame.
- R5: The load edge is the clock edge that ends a frame's end bit. The kind of frame and its word are sampled only there. A sync request that is high only between load edges has no effect on any frame.
- R6: `word_strobe` high at any clock edge captures `data_in`. A data frame carries the most recent word captured at or before its load edge. With no new strobe, the previous word is sent again.
- R7: While a sync request stays high, every frame is a training frame. The first load edge after it falls resumes data frames.
- R8: `ser_oe` equals `drv_en` delayed by one clock. While `ser_oe` is low, `ser_out` is 1. The enable never shifts the frame timing.
- R9: Reset is synchronous and active low. In reset, `ser_out` is 1 and `ser_oe` and `frame_start` are 0, and the held word is zero. The first start bit appears in the cycle after the first clock edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_strobe | input | 1 | Captures `data_in` at the clock edge |
| data_in | input | DATA_W | Parallel word |
| sync_req_a | input | 1 | Training request, first source |
| sync_req_b | input | 1 | Training request, second source |
| drv_en | input | 1 | Line driver enable request |
| ser_out | output | 1 | Serial line, high when disabled |
| ser_oe | output | 1 | Registered driver enable |
| frame_start | output | 1 | High in the start-bit cycle |

## Verification
The bench builds the block with the default DATA_W of 10, which gives the 12-bit frame and the six-and-six training pattern. At that width, every data bit position and both training halves are visible within one frame. The word patterns are chosen so that swapping adjacent bits, reversing the order or shifting the frame by one position changes the observed frame. Mid-frame sync pulses and mid-frame strobes sit well away from the load edge, so frames remain complete rather than mixed. The bench also runs repeated training frames and a frame with the driver disabled.

// File: rtl/ser_pkg.sv
// Shared types for the framed serializer.
// Assumes nothing beyond the frame kinds listed here.
package ser_pkg;
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_SYNC = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/ser_word_hold.sv
// Word holding register: captures data_in whenever word_strobe is high and
// presents the word a frame loaded at this edge should carry (a word strobed
// in the load cycle itself bypasses the register).
// Assumes: word_strobe may arrive in any cycle.
module ser_word_hold #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_strobe,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] next_word
);
    logic [DATA_W-1:0] held_q;

    // Capture the strobed word; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (word_strobe) begin
            held_q <= data_in;
        end
    end

    // Same-cycle strobe wins over the held word.
    always_comb begin
        next_word = word_strobe ? data_in : held_q;
    end
endmodule

// File: rtl/ser_frame_build.sv
// Frame builder: forms the FRAME_W-bit frame, bit 0 sent first.
// Data kind: 1, word LSB..MSB, 0.  Sync kind: FRAME_W/2 ones then zeros.
// Assumes: purely combinational, evaluated only at the load edge.
module ser_frame_build
    import ser_pkg::*;
#(
    parameter int DATA_W  = 10,
    localparam int FRAME_W = DATA_W + 2
) (
    input  frame_kind_e        kind,
    input  logic [DATA_W-1:0]  word,
    output logic [FRAME_W-1:0] frame
);
    localparam int SYNC_ONES = FRAME_W / 2;

    logic [FRAME_W-1:0] sync_pat;
    logic [FRAME_W-1:0] data_pat;

    // Training pattern: low half of the time slots high.
    for (genvar i = 0; i < FRAME_W; i++) begin : g_sync
        assign sync_pat[i] = (i < SYNC_ONES);
    end

    // Data pattern with framing bits around the word.
    assign data_pat = {1'b0, word, 1'b1};

    // Select the frame kind.
    always_comb begin
        frame = (kind == KIND_SYNC) ? sync_pat : data_pat;
    end
endmodule

// File: rtl/ser_bit_timer.sv
// Bit position counter: walks 0..FRAME_W-1 and flags the last slot (the
// load edge follows it) and the first slot (start bit on the line).
// Assumes: reset parks the counter on the last slot so a frame loads on the
// first edge after reset.
module ser_bit_timer #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic at_last,
    output logic at_first
);
    localparam int CW = $clog2(FRAME_W);
    localparam logic [CW-1:0] LAST_POS = CW'(FRAME_W - 1);

    logic [CW-1:0] pos_q;

    // Advance one slot per clock and wrap after the end bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST_POS;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Decode the slot flags.
    always_comb begin
        at_last  = (pos_q == LAST_POS) && rst_n;
        at_first = (pos_q == '0);
    end
endmodule

// File: rtl/ser_shifter.sv
// Output shift register: loads a whole frame on load, otherwise shifts
// toward bit 0, filling with ones. Bit 0 is the bit on the line.
// Assumes: load is asserted only in the last slot of a frame.
module ser_shifter #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               line_bit
);
    logic [FRAME_W-1:0] sh_q;

    // Load a frame or shift the current one out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= frame_in;
        end else begin
            sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
        end
    end

    assign line_bit = sh_q[0];
endmodule

// File: rtl/framed_serializer.sv
// Framed serializer top: one serial bit per clock, frames back to back.
// Sync requests and the word are sampled only at the load edge; the driver
// enable is registered and parks the line high while off.
// Assumes: clk is the bit clock; inputs are synchronous to it.
module framed_serializer
    import ser_pkg::*;
#(
    parameter int DATA_W  = 10,
    localparam int FRAME_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic              sync_req_a,
    input  logic              sync_req_b,
    input  logic              drv_en,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              frame_start
);
    logic [DATA_W-1:0]  next_word;
    logic [FRAME_W-1:0] frame;
    logic               at_last;
    logic               at_first;
    logic               line_bit;
    logic               oe_q;
    frame_kind_e        kind;

    // Either request selects a training frame.
    always_comb begin
        kind = (sync_req_a || sync_req_b) ? KIND_SYNC : KIND_DATA;
    end

    ser_word_hold #(.DATA_W(DATA_W)) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_strobe (word_strobe),
        .data_in     (data_in),
        .next_word   (next_word)
    );

    ser_frame_build #(.DATA_W(DATA_W)) i_build (
        .kind  (kind),
        .word  (next_word),
        .frame (frame)
    );

    ser_bit_timer #(.FRAME_W(FRAME_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_last  (at_last),
        .at_first (at_first)
    );

    ser_shifter #(.FRAME_W(FRAME_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (at_last),
        .frame_in (frame),
        .line_bit (line_bit)
    );

    // Register the driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= drv_en;
        end
    end

    // Drive outputs; a disabled line idles high.
    always_comb begin
        ser_oe      = oe_q;
        ser_out     = oe_q ? line_bit : 1'b1;
        frame_start = at_first && rst_n;
    end
endmodule

// File: rtl/ser_checker.sv
// Assertion checker for framed_serializer, attached by bind below.
// Assumes: observes the top-level ports only.
module ser_checker #(
    parameter int FRAME_W = 12
) (
    input logic clk,
    input logic rst_n,
    input logic drv_en,
    input logic ser_out,
    input logic ser_oe,
    input logic frame_start
);
    logic        seen_q;
    logic [15:0] gap_q;

    // Cycles since the previous frame_start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (frame_start) begin
            seen_q <= 1'b1;
            gap_q  <= 16'd1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q  <= gap_q + 16'd1;
        end
    end

    // R1: frame markers are exactly FRAME_W cycles apart
    a_r1_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_q) |-> (gap_q == 16'(FRAME_W)));

    // R1: the marked cycle carries a high start bit
    a_r1_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && ser_oe) |-> ser_out);

    // R2: the slot before each start bit is a low end bit
    a_r2_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_q && $past(ser_oe)) |-> ($past(ser_out) == 1'b0));

    // R8: disabled line idles high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> ser_out);

    // R8: enable follows the request one clock later
    a_r8_oe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ser_oe == $past(drv_en)));
endmodule

bind framed_serializer ser_checker #(.FRAME_W(FRAME_W)) i_ser_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_en      (drv_en),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .frame_start (frame_start)
);

// File: tb/test_framed_serializer.sv
module test_framed_serializer;
    localparam int DW = 10;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_strobe = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          sync_req_a = 1'b0;
    logic          sync_req_b = 1'b0;
    logic          drv_en = 1'b0;
    logic          ser_out;
    logic          ser_oe;
    logic          frame_start;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [FW-1:0] exp_q[$];
    logic          oe_q[$];
    string         tag_q[$];
    logic [DW-1:0] model_hold = '0;

    always #4 clk = ~clk;   // 125 MHz

    framed_serializer #(.DATA_W(DW)) i_framed_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_strobe (word_strobe),
        .data_in     (data_in),
        .sync_req_a  (sync_req_a),
        .sync_req_b  (sync_req_b),
        .drv_en      (drv_en),
        .ser_out     (ser_out),
        .ser_oe      (ser_oe),
        .frame_start (frame_start)
    );

    task automatic check(input bit ok, input string tag, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected frame in time order (bit 0 first on the line).
    function automatic logic [FW-1:0] mk(input logic s, input logic [DW-1:0] w);
        logic [FW-1:0] f;
        if (s) begin
            for (int i = 0; i < FW; i++) f[i] = (i < FW / 2);
        end else begin
            f[0] = 1'b1;
            for (int i = 0; i < DW; i++) f[i + 1] = w[i];
            f[FW - 1] = 1'b0;
        end
        return f;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: called in the last slot of a frame, returns in the next last slot.
    // mid: 0 none, 1 sync pulse mid-frame, 2 word strobe mid-frame.
    task automatic drive_frame(input logic sa, input logic sb, input logic st,
                               input logic [DW-1:0] d, input int mid,
                               input logic [DW-1:0] md, input logic en,
                               input string tag);
        sync_req_a  = sa;
        sync_req_b  = sb;
        word_strobe = st;
        data_in     = d;
        drv_en      = en;
        if (st) model_hold = d;
        exp_q.push_back(en ? mk(sa | sb, model_hold) : {FW{1'b1}});
        oe_q.push_back(en);
        tag_q.push_back(tag);
        step();                      // slot 0
        word_strobe = 1'b0;
        for (int i = 0; i < 4; i++) step();   // slot 4
        if (mid == 1) begin
            sync_req_a = 1'b1;
            step();
            sync_req_a = 1'b0;
        end else if (mid == 2) begin
            word_strobe = 1'b1;
            data_in     = md;
            model_hold  = md;
            step();
            word_strobe = 1'b0;
        end else begin
            step();
        end
        for (int i = 0; i < FW - 6; i++) step();   // slot FW-1
    endtask

    // Monitor: collects frames at the falling edge and compares them.
    int            idx = -1;
    int            since_rst = 0;
    int            gap = 0;
    bit            first_seen = 1'b0;
    logic [FW-1:0] got;
    logic          got_oe;
    always @(negedge clk) begin
        if (!rst_n) begin
            since_rst = 0;
        end else begin
            since_rst++;
            gap++;
            if (frame_start) begin
                if (!first_seen) begin
                    check(since_rst == 2, "R9 first start timing", FW'(since_rst), FW'(2));
                    first_seen = 1'b1;
                end else begin
                    check(gap == FW && idx == FW, "R1 start spacing", FW'(gap), FW'(FW));
                end
                gap = 0;
                idx = 0;
            end
            if (idx >= 0 && idx < FW) begin
                got[idx] = ser_out;
                if (idx == 0) got_oe = ser_oe;
                idx++;
                if (idx == FW && exp_q.size() > 0) begin
                    logic [FW-1:0] e;
                    logic          eo;
                    string         t;
                    e  = exp_q.pop_front();
                    eo = oe_q.pop_front();
                    t  = tag_q.pop_front();
                    check(got == e, t, got, e);
                    check(got_oe == eo, {t, " oe"}, FW'(got_oe), FW'(eo));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(ser_out == 1'b1, "R9 reset ser_out", FW'(ser_out), FW'(1));
        check(ser_oe == 1'b0, "R9 reset ser_oe", FW'(ser_oe), FW'(0));
        check(frame_start == 1'b0, "R9 reset frame_start", FW'(frame_start), FW'(0));
        step();
        rst_n = 1'b1;
        drive_frame(0, 0, 1, 10'h2A5, 0, '0, 1, "R2 word 2A5");
        drive_frame(0, 0, 1, 10'h3FE, 0, '0, 1, "R2 word 3FE");
        drive_frame(0, 0, 0, 10'h000, 2, 10'h155, 1, "R6 old word before mid strobe");
        drive_frame(0, 0, 0, 10'h000, 0, '0, 1, "R6 mid-frame strobe word");
        drive_frame(0, 0, 0, 10'h0AA, 0, '0, 1, "R6 repeat without strobe");
        drive_frame(1, 0, 0, 10'h000, 0, '0, 1, "R3 R4 sync via a");
        drive_frame(0, 1, 0, 10'h000, 0, '0, 1, "R4 sync via b");
        drive_frame(1, 1, 0, 10'h000, 0, '0, 1, "R4 sync via both");
        drive_frame(1, 0, 0, 10'h000, 0, '0, 1, "R7 held sync 1");
        drive_frame(1, 0, 0, 10'h000, 0, '0, 1, "R7 held sync 2");
        drive_frame(0, 0, 1, 10'h0F0, 0, '0, 1, "R7 data after release");
        drive_frame(0, 0, 1, 10'h001, 1, '0, 1, "R5 data despite mid sync");
        drive_frame(0, 0, 0, 10'h000, 0, '0, 1, "R5 mid pulse no effect");
        drive_frame(0, 0, 1, 10'h3C3, 0, '0, 0, "R8 disabled idles high");
        drive_frame(0, 0, 0, 10'h000, 0, '0, 1, "R8 timing kept after enable");
        drive_frame(0, 1, 1, 10'h207, 0, '0, 1, "R4 sync wins over strobe");
        drive_frame(0, 0, 0, 10'h000, 0, '0, 1, "R6 word captured during sync");
        repeat (FW + 3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all frames seen", FW'(exp_q.size()), FW'(0));
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule